// File: doc/BRIEF.md
# Vector memory address generator

This block turns one vector load or store instruction into a stream of per-element byte addresses for a memory port. It is started with an addressing mode, a scalar base, a scalar stride, a requested element count and a per-element predicate word. It then steps through elements 0 up to the active length minus one and presents one request per element. Each request carries the address, the element number and a write-enable.

Three addressing modes are supported. Consecutive mode walks memory in element-size steps. Strided mode walks in steps of the stride register times the element size. Indexed mode, for gather and scatter, adds a per-element offset to the base. That offset is read from a vector register through the `idx_in` input, which must present the entry for the element shown on `req_elem`. The memory port applies back-pressure through `req_ready`. Completion is signalled by a one-cycle `done` pulse. Elements are 8 bytes wide and the active length is at most 64.

Top module: `vmem_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `req_valid`, `req_wen` and `done` are all 0.
- R2: With `mode` = 0 (consecutive; encoding 3 behaves the same), element i is addressed at `base` + 8*i.
- R3: With `mode` = 1 (strided), element i is addressed at `base` + 8*i*`stride`, computed modulo 2^32. A stride with the top bit set therefore walks downward.
- R4: With `mode` = 2 (indexed), element i is addressed at `base` + `idx_in`. Here `idx_in` is an unscaled byte offset, sampled while `req_elem` = i.
- R5: The active length is min(`vlen`, 64). Exactly the elements 0 .. length-1 are requested, once each and in increasing order. The first request is valid in the cycle after `start` is accepted.
- R6: `req_wen` is 1 only for a store (`is_store` = 1) whose element has bit i of `mask` set. For loads, and for store elements whose mask bit is clear, it is 0. The address is still requested in both cases.
- R7: While `req_valid` is 1 and `req_ready` is 0, the next cycle shows the same request: the same `req_elem`, `req_wen` and `req_addr`, and `req_valid` still 1.
- R8: `done` is 1 for exactly one cycle, in the cycle after the last element is accepted.
- R9: A `vlen` of 0 issues no request and raises `done` in the cycle after `start`.
- R10: `start` is accepted only when `busy` is 0. `busy` is 1 from the cycle after acceptance up to and including the `done` cycle. A `start` while busy has no effect on the request stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| mode | input | 2 | 0 consecutive, 1 strided, 2 indexed, 3 as 0 |
| base | input | 32 | Scalar base byte address |
| stride | input | 32 | Stride in elements (strided mode) |
| vlen | input | 7 | Requested element count, capped at 64 |
| mask | input | 64 | Per-element write predicate, bit i for element i |
| is_store | input | 1 | 1 for store, 0 for load |
| busy | output | 1 | Instruction in progress |
| idx_in | input | 32 | Index byte offset for element `req_elem` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory port accepts the request |
| req_addr | output | 32 | Element byte address |
| req_elem | output | 6 | Element number |
| req_wen | output | 1 | Write-enable for this element |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request is due in the cycle after the `start` edge. Each later request is due in the cycle after the previous one is accepted. `done` is due one cycle after the last acceptance, and for a zero length one cycle after `start`. `busy` is checked in the cycle right after `start` is taken. Inputs change just after a rising edge and outputs are sampled on the falling edge. The scoreboard pops an expected item only in a cycle where `req_valid` and `req_ready` are both high. It arms the `done` check for exactly the next sample. Stalled cycles are compared against the request seen in the cycle before.

// File: rtl/vag_pkg.sv
package vag_pkg;
    parameter int ADDR_W     = 32;
    parameter int MAX_VL     = 64;
    parameter int ELEM_BYTES = 8;

    localparam int EL_W  = $clog2(MAX_VL);
    localparam int VL_W  = EL_W + 1;
    localparam int SCALE = $clog2(ELEM_BYTES);

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_ALT    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [VL_W-1:0]   vl;
        logic [MAX_VL-1:0] pred;
        logic              store;
    } instr_ctl_t;

    typedef struct packed {
        amode_e             mode;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  step;
    } instr_adr_t;

    function automatic logic [VL_W-1:0] clamp_len(input logic [VL_W-1:0] n);
        return (n > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : n;
    endfunction

    function automatic logic [ADDR_W-1:0] scale_step(input amode_e m,
                                                    input logic [ADDR_W-1:0] s);
        if (m == AM_STRIDE)
            return s << SCALE;
        return ADDR_W'(ELEM_BYTES);
    endfunction
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
    import vag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VL_W-1:0]   vlen,
    input  logic [MAX_VL-1:0] mask,
    input  logic              is_store,
    input  logic              ready,
    output logic              load,
    output logic              adv,
    output logic              valid,
    output logic [EL_W-1:0]   elem,
    output logic              wen,
    output logic              busy,
    output logic              done
);
    seq_state_e      st;
    instr_ctl_t      ic;
    logic [VL_W-1:0] cnt;
    logic [VL_W-1:0] len_c;
    logic            last;

    always_comb begin
        len_c = clamp_len(vlen);
        load  = start && (st == ST_IDLE);
        valid = (st == ST_RUN);
        adv   = valid && ready;
        last  = (cnt == ic.vl - VL_W'(1));
        elem  = cnt[EL_W-1:0];
        wen   = valid && ic.store && ic.pred[cnt[EL_W-1:0]];
        busy  = (st != ST_IDLE);
        done  = (st == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ic  <= '0;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    ic  <= '{vl: len_c, pred: mask, store: is_store};
                    cnt <= '0;
                    st  <= (len_c == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (adv) begin
                    if (last) st  <= ST_FIN;
                    else      cnt <= cnt + VL_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: every request lies inside the active length
    a_r5_elem_in_range: assert property (@(posedge clk) disable iff (rst)
        valid |-> (cnt < ic.vl));
    // R5: accepted non-final element advances by one
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (adv && !last) |=> (valid && cnt == $past(cnt) + VL_W'(1)));
    // R7: stall keeps the request
    a_r7_hold_elem: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(cnt) && $stable(wen)));
    // R8: completion pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: final acceptance is followed by completion
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (done && !valid));
    // R10: a start while busy leaves the captured instruction alone
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ic));
endmodule

// File: rtl/vag_addr.sv
module vag_addr
    import vag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [ADDR_W-1:0] idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    instr_adr_t        ia;
    logic [ADDR_W-1:0] acc;
    amode_e            m_in;

    always_comb begin
        m_in   = amode_e'(mode_i);
        addr_o = ia.base + ((ia.mode == AM_INDEX) ? idx_i : acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ia  <= '{mode: AM_UNIT, base: '0, step: '0};
            acc <= '0;
        end else if (load) begin
            ia  <= '{mode: m_in, base: base_i, step: scale_step(m_in, stride_i)};
            acc <= '0;
        end else if (adv) begin
            acc <= acc + ia.step;
        end
    end

    // R7: outside indexed mode the address holds when nothing advances
    a_r7_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load && ia.mode != AM_INDEX) |=> $stable(addr_o));
    // R2: consecutive mode always moves by one element size
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && (ia.mode == AM_UNIT || ia.mode == AM_ALT))
        |=> (addr_o == $past(addr_o) + ADDR_W'(ELEM_BYTES)));
endmodule

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen
    import vag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vlen,
    input  logic [MAX_VL-1:0] mask,
    input  logic              is_store,
    output logic              busy,
    input  logic [ADDR_W-1:0] idx_in,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [EL_W-1:0]   req_elem,
    output logic              req_wen,
    output logic              done
);
    logic load, adv;

    vag_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vlen     (vlen),
        .mask     (mask),
        .is_store (is_store),
        .ready    (req_ready),
        .load     (load),
        .adv      (adv),
        .valid    (req_valid),
        .elem     (req_elem),
        .wen      (req_wen),
        .busy     (busy),
        .done     (done)
    );

    vag_addr u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv      (adv),
        .mode_i   (mode),
        .base_i   (base),
        .stride_i (stride),
        .idx_i    (idx_in),
        .addr_o   (req_addr)
    );

    // R6: a write-enable never appears without a request
    a_r6_wen_needs_valid: assert property (@(posedge clk) disable iff (rst)
        req_wen |-> req_valid);
    // R9: completion never coincides with a request
    a_r9_done_no_req: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);
endmodule

// File: tb/vmem_addr_gen_tb_top.sv
`timescale 1ns/1ps
module vmem_addr_gen_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [1:0]  mode = 0;
    logic [31:0] base = 0, stride = 0;
    logic [6:0]  vlen = 0;
    logic [63:0] mask = 0;
    logic        is_store = 0;
    logic        busy, req_valid, req_wen, done;
    logic        req_ready = 1;
    logic [31:0] idx_in, req_addr;
    logic [5:0]  req_elem;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] a;
        logic [5:0]  e;
        logic        w;
        logic        last;
    } exp_t;
    exp_t q[$];

    logic [31:0] idx_tab [64];
    logic        zl = 0;
    logic        rnd_rdy = 0;
    logic [7:0]  lf = 8'h5a;
    int          accepted = 0;

    always #2 clk = ~clk;

    assign idx_in = idx_tab[req_elem];

    vmem_addr_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
        .stride(stride), .vlen(vlen), .mask(mask), .is_store(is_store),
        .busy(busy), .idx_in(idx_in), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
        .req_wen(req_wen), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        req_ready = rnd_rdy ? (lf[0] | lf[2]) : 1'b1;
    end

    // monitor / scoreboard
    logic        done_due = 0, stalled = 0;
    logic [31:0] p_a;
    logic [5:0]  p_e;
    logic        p_w;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_due) begin
                chk(done === 1'b1, "R8 done after last", {63'd0, done}, 64'd1);
                done_due = 0;
            end else if (done && !zl) begin
                chk(0, "R8 spurious done", 64'd1, 64'd0);
            end
            if (stalled) begin
                chk(req_valid && req_addr == p_a && req_elem == p_e && req_wen == p_w,
                    "R7 stall hold", {req_addr, 26'd0, req_elem}, {p_a, 26'd0, p_e});
            end
            stalled = req_valid && !req_ready;
            p_a = req_addr; p_e = req_elem; p_w = req_wen;
            if (req_valid && req_ready) begin
                accepted++;
                if (q.size() == 0) begin
                    chk(0, "R5 unexpected request", {58'd0, req_elem}, 64'd0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    chk(req_addr == x.a, "R2/R3/R4 address", {32'd0, req_addr}, {32'd0, x.a});
                    chk(req_elem == x.e, "R5 element order", {58'd0, req_elem}, {58'd0, x.e});
                    chk(req_wen == x.w, "R6 write enable", {63'd0, req_wen}, {63'd0, x.w});
                    if (x.last) done_due = 1;
                end
            end
        end
    end

    task automatic issue(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                         input logic [6:0] n, input logic [63:0] mk, input logic st,
                         input bit wait_end);
        int len;
        len = (n > 7'd64) ? 64 : int'(n);
        for (int i = 0; i < len; i++) begin
            exp_t x;
            if (m == 2'd1)      x.a = b + 32'(i) * s * 32'd8;
            else if (m == 2'd2) x.a = b + idx_tab[i];
            else                x.a = b + 32'(i) * 32'd8;
            x.e = 6'(i);
            x.w = st & mk[i];
            x.last = (i == len - 1);
            q.push_back(x);
        end
        zl = (len == 0);
        @(posedge clk); #1;
        start = 1; mode = m; base = b; stride = s; vlen = n; mask = mk; is_store = st;
        @(posedge clk); #1;
        start = 0;
        @(negedge clk);
        chk(busy === 1'b1, "R10 busy after start", {63'd0, busy}, 64'd1);
        if (len == 0) begin
            chk(done === 1'b1 && req_valid === 1'b0, "R9 zero length done",
                {62'd0, done, req_valid}, 64'd2);
        end
        if (wait_end) begin
            while (busy) @(negedge clk);
            chk(q.size() == 0, "R5 all elements requested", 64'(q.size()), 64'd0);
            zl = 0;
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) idx_tab[i] = 32'(i * 37 + 5) ^ 32'(i << 9);
        repeat (3) @(negedge clk);
        chk(busy === 0 && req_valid === 0 && done === 0 && req_wen === 0,
            "R1 reset state", {60'd0, busy, req_valid, done, req_wen}, 64'd0);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        chk(busy === 0 && req_valid === 0 && done === 0, "R1 after reset",
            {61'd0, busy, req_valid, done}, 64'd0);

        // R2 consecutive load
        issue(2'd0, 32'h0000_1000, 32'd0, 7'd5, 64'hFFFF, 1'b0, 1);
        // R6 masked store, random back-pressure (R7)
        rnd_rdy = 1;
        issue(2'd0, 32'h0002_0000, 32'd0, 7'd10, 64'h0000_0000_0000_02A5, 1'b1, 1);
        // R3 strided, positive and negative stride
        issue(2'd1, 32'h0000_4000, 32'd3, 7'd7, 64'h0, 1'b0, 1);
        issue(2'd1, 32'h0000_0100, 32'hFFFF_FFFE, 7'd4, 64'hF, 1'b1, 1);
        // R4 indexed scatter with mask
        issue(2'd2, 32'h8000_0000, 32'd0, 7'd8, 64'h0000_0000_0000_00C3, 1'b1, 1);
        // mode 3 behaves as consecutive (R2)
        issue(2'd3, 32'h0000_0040, 32'd9, 7'd3, 64'h0, 1'b0, 1);
        // R9 zero length
        issue(2'd0, 32'h0000_1000, 32'd0, 7'd0, 64'h0, 1'b1, 1);
        // R5 length clamp at 64 and full length
        accepted = 0;
        issue(2'd1, 32'h0010_0000, 32'd2, 7'd100, 64'hAAAA_5555_0F0F_F0F0, 1'b1, 1);
        chk(accepted == 64, "R5 clamp to 64", 64'(accepted), 64'd64);
        rnd_rdy = 0;
        accepted = 0;
        issue(2'd2, 32'h0000_0000, 32'd0, 7'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1);
        chk(accepted == 64, "R5 full length", 64'(accepted), 64'd64);

        // R10 start while busy is ignored
        rnd_rdy = 1;
        accepted = 0;
        issue(2'd0, 32'h0000_3000, 32'd0, 7'd6, 64'h3F, 1'b1, 0);
        @(posedge clk); #1;
        start = 1; mode = 2'd1; base = 32'hDEAD_0000; stride = 32'd5; vlen = 7'd9;
        @(posedge clk); #1;
        start = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(accepted == 6 && q.size() == 0, "R10 start while busy ignored",
            64'(accepted), 64'd6);
        chk(busy === 0 && req_valid === 0, "R10 idle afterwards",
            {62'd0, busy, req_valid}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule